// File: doc/BRIEF.md
# Sector DMA Engine with Field-Wrapped Addressing

This block copies one disk sector between a word-addressed disk store and main memory each time it is started. The caller presents a direction, a half-sector flag, a three-bit memory field, a 12-bit in-field memory address, a cylinder high bit and a 12-bit disk address, together with the present and protected status of the selected drive. The engine then streams the words through two simple synchronous RAM ports, one word per clock. It advances its memory-address register by the number of memory words moved and pulses done.

The memory address never carries into the field bits. When the in-field address passes the end of the 4096-word field, it wraps to offset zero of the same field. A half-sector transfer moves 128 words from or to memory. In the write direction, the other 128 words of the disk sector are filled with zeros, so a whole sector is always written to disk. A stall input holds back the fetch of new words. Words already fetched still land one cycle later.

Top module: `sdma_engine`

## Requirements
- R1: After synchronous reset, busy, done, all three fault flags, both write strobes and ma_out are 0.
- R2: start is accepted only while busy is 0. An accepted start with a present drive, and not a write to a protected drive, sets busy on the next cycle. A start while busy has no effect on the running transfer, its addresses or ma_out.
- R3: The memory address of word i is {field, (ma + i) mod 4096}: the field bits come straight from op_ext and never change during a transfer.
- R4: The disk address of word i is S*256 + i, with linear sector S = {op_cyl_hi, op_daddr}. In op_daddr, bits 3:0 select the sector, bit 4 the surface, and bits 11:5 the low cylinder bits, so S = cylinder*32 + surface*16 + sector.
- R5: With op_write = 0 (disk to memory), 256 words are copied, or the first 128 when op_half = 1.
- R6: With op_write = 1 (memory to disk), 256 memory words are copied. With op_half = 1, 128 memory words are copied and disk words 128..255 of the sector are written with 0.
- R7: Each clock with stall = 0 fetches one source word. Its destination write happens on the next clock. A clock with stall = 1 fetches nothing, and no word is lost or repeated.
- R8: One clock after the last destination write, done is high for one cycle, busy is 0 and ma_out equals the start address plus 128 (half) or 256 (full), modulo 4096.
- R9: A start with drv_present = 0 writes nothing. On the next cycle it sets done, err_not_ready and err_drive, leaves busy at 0 and leaves ma_out unchanged.
- R10: A write start with drv_protect = 1 writes nothing to disk and sets done and err_wlock with busy at 0. A read from a protected drive proceeds normally.
- R11: Every start taken while idle first clears all three fault flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sector transfer |
| op_write | input | 1 | 1 = memory to disk, 0 = disk to memory |
| op_half | input | 1 | Move only 128 memory words |
| op_ext | input | 3 | Memory field |
| op_cyl_hi | input | 1 | Most significant cylinder bit |
| op_daddr | input | 12 | Disk address: cylinder low bits, surface, sector |
| op_maddr | input | 12 | In-field memory start address |
| drv_present | input | 1 | Selected drive present |
| drv_protect | input | 1 | Selected drive write-protected |
| stall | input | 1 | Hold back fetching of the next word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion or abort pulse |
| err_not_ready | output | 1 | Drive absent at start |
| err_drive | output | 1 | Drive status error at start |
| err_wlock | output | 1 | Write to a protected drive refused |
| ma_out | output | 12 | Memory-address register |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, one cycle after mem_en |
| dsk_en | output | 1 | Disk store access enable |
| dsk_we | output | 1 | Disk store write enable |
| dsk_addr | output | 21 | Disk store word address |
| dsk_wdata | output | 12 | Disk store write data |
| dsk_rdata | input | 12 | Disk store read data, one cycle after dsk_en |

## Verification
The bench builds the engine with its default parameters: 12-bit words, a 12-bit in-field address, three field bits and 256-word sectors. These are the real sizes, so memory-field wrap at offset 4095 and half-sector zero padding can be reached with ordinary start addresses. The sector numbers exercised include the one where the cylinder high bit and every disk-address bit are set. Both RAMs are modelled as sparse arrays that read zero where nothing was written.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int WORD_W_DEF   = 12;
    localparam int OFS_W_DEF    = 12;
    localparam int EXT_W_DEF    = 3;
    localparam int SECT_LOG_DEF = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef enum logic [0:0] {
        DIR_TO_MEM  = 1'b0,
        DIR_TO_DISK = 1'b1
    } dir_t;

    typedef struct packed {
        logic not_ready;
        logic drive_err;
        logic wlock;
    } fault_t;

    // Faults decided at the moment a start is taken.
    function automatic fault_t screen_start(input logic present,
                                            input logic protect,
                                            input dir_t dir);
        fault_t f;
        f = '0;
        if (!present) begin
            f.not_ready = 1'b1;
            f.drive_err = 1'b1;
        end else if (protect && dir == DIR_TO_DISK) begin
            f.wlock = 1'b1;
        end
        return f;
    endfunction

    // A slot in the upper half of a half-sector write carries zero fill.
    function automatic logic pad_slot(input dir_t dir, input logic half,
                                      input logic upper);
        return (dir == DIR_TO_DISK) && half && upper;
    endfunction

endpackage

// File: rtl/sdma_seq.sv
module sdma_seq
    import sdma_pkg::*;
#(
    parameter int OFS_W    = OFS_W_DEF,
    parameter int EXT_W    = EXT_W_DEF,
    parameter int SECT_LOG = SECT_LOG_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                op_write,
    input  logic                op_half,
    input  logic [EXT_W-1:0]    op_ext,
    input  logic                op_cyl_hi,
    input  logic [OFS_W-1:0]    op_daddr,
    input  logic [OFS_W-1:0]    op_maddr,
    input  logic                drv_present,
    input  logic                drv_protect,
    input  logic                stall,
    output logic                busy,
    output logic                done,
    output fault_t              faults,
    output logic [OFS_W-1:0]    ma_q,
    output logic [EXT_W-1:0]    ext_q,
    output logic [OFS_W:0]      snum_q,
    output dir_t                dir_q,
    output logic                half_q,
    output logic                issue,
    output logic [SECT_LOG-1:0] iss_idx,
    output logic                s2_v,
    output logic [SECT_LOG-1:0] s2_idx
);
    localparam int CNT_W = SECT_LOG + 1;
    localparam logic [CNT_W-1:0] FULL_N = CNT_W'(1) << SECT_LOG;
    localparam logic [CNT_W-1:0] HALF_N = FULL_N >> 1;

    run_state_t        state;
    logic [CNT_W-1:0]  iss_cnt;
    logic [CNT_W-1:0]  total;
    logic [CNT_W-1:0]  mem_words;
    logic              last_wr;
    fault_t            chk;
    dir_t              dir_in;

    assign dir_in    = op_write ? DIR_TO_DISK : DIR_TO_MEM;
    assign chk       = screen_start(drv_present, drv_protect, dir_in);
    assign mem_words = half_q ? HALF_N : FULL_N;
    assign total     = (dir_q == DIR_TO_DISK) ? FULL_N : mem_words;
    assign issue     = (state == ST_RUN) && !stall && (iss_cnt < total);
    assign iss_idx   = iss_cnt[SECT_LOG-1:0];
    assign last_wr   = s2_v && ({1'b0, s2_idx} == total - CNT_W'(1));
    assign busy      = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            faults  <= '0;
            ma_q    <= '0;
            ext_q   <= '0;
            snum_q  <= '0;
            dir_q   <= DIR_TO_MEM;
            half_q  <= 1'b0;
            iss_cnt <= '0;
            s2_v    <= 1'b0;
            s2_idx  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    s2_v <= 1'b0;
                    if (start) begin
                        faults <= chk;
                        if (chk == '0) begin
                            state   <= ST_RUN;
                            ma_q    <= op_maddr;
                            ext_q   <= op_ext;
                            snum_q  <= {op_cyl_hi, op_daddr};
                            dir_q   <= dir_in;
                            half_q  <= op_half;
                            iss_cnt <= '0;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (issue) iss_cnt <= iss_cnt + CNT_W'(1);
                    s2_v   <= issue;
                    s2_idx <= iss_idx;
                    if (last_wr) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        ma_q  <= ma_q + OFS_W'(mem_words);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sdma_addr.sv
module sdma_addr #(
    parameter int OFS_W    = 12,
    parameter int EXT_W    = 3,
    parameter int SECT_LOG = 8
) (
    input  logic [EXT_W-1:0]          ext,
    input  logic [OFS_W-1:0]          ma,
    input  logic [OFS_W:0]            snum,
    input  logic [SECT_LOG-1:0]       idx,
    output logic [EXT_W+OFS_W-1:0]    pa,
    output logic [OFS_W+SECT_LOG:0]   da
);
    logic [OFS_W-1:0] ofs;

    // In-field sum drops its carry: the field bits stay fixed.
    assign ofs = ma + OFS_W'(idx);
    assign pa  = {ext, ofs};
    assign da  = {snum, idx};

endmodule

// File: rtl/sdma_port.sv
module sdma_port
    import sdma_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int PA_W   = 15,
    parameter int DA_W   = 21
) (
    input  dir_t              dir,
    input  logic              half,
    input  logic              issue,
    input  logic              iss_upper,
    input  logic              s2_v,
    input  logic              s2_upper,
    input  logic [PA_W-1:0]   src_pa,
    input  logic [DA_W-1:0]   src_da,
    input  logic [PA_W-1:0]   dst_pa,
    input  logic [DA_W-1:0]   dst_da,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] dsk_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              dsk_en,
    output logic              dsk_we,
    output logic [DA_W-1:0]   dsk_addr,
    output logic [WORD_W-1:0] dsk_wdata
);
    always_comb begin
        mem_wdata = dsk_rdata;
        dsk_wdata = pad_slot(dir, half, s2_upper) ? '0 : mem_rdata;
        if (dir == DIR_TO_MEM) begin
            dsk_en   = issue;
            dsk_we   = 1'b0;
            dsk_addr = src_da;
            mem_en   = s2_v;
            mem_we   = s2_v;
            mem_addr = dst_pa;
        end else begin
            mem_en   = issue && !pad_slot(dir, half, iss_upper);
            mem_we   = 1'b0;
            mem_addr = src_pa;
            dsk_en   = s2_v;
            dsk_we   = s2_v;
            dsk_addr = dst_da;
        end
    end

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int WORD_W   = WORD_W_DEF,
    parameter int OFS_W    = OFS_W_DEF,
    parameter int EXT_W    = EXT_W_DEF,
    parameter int SECT_LOG = SECT_LOG_DEF,
    localparam int PA_W    = EXT_W + OFS_W,
    localparam int DA_W    = OFS_W + 1 + SECT_LOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_write,
    input  logic              op_half,
    input  logic [EXT_W-1:0]  op_ext,
    input  logic              op_cyl_hi,
    input  logic [OFS_W-1:0]  op_daddr,
    input  logic [OFS_W-1:0]  op_maddr,
    input  logic              drv_present,
    input  logic              drv_protect,
    input  logic              stall,
    output logic              busy,
    output logic              done,
    output logic              err_not_ready,
    output logic              err_drive,
    output logic              err_wlock,
    output logic [OFS_W-1:0]  ma_out,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              dsk_en,
    output logic              dsk_we,
    output logic [DA_W-1:0]   dsk_addr,
    output logic [WORD_W-1:0] dsk_wdata,
    input  logic [WORD_W-1:0] dsk_rdata
);
    fault_t              faults;
    logic [EXT_W-1:0]    ext_q;
    logic [OFS_W:0]      snum_q;
    dir_t                dir_q;
    logic                half_q;
    logic                issue;
    logic                s2_v;
    logic [SECT_LOG-1:0] iss_idx;
    logic [SECT_LOG-1:0] s2_idx;
    logic [PA_W-1:0]     pa_slot [2];
    logic [DA_W-1:0]     da_slot [2];
    logic [SECT_LOG-1:0] idx_slot [2];

    sdma_seq #(.OFS_W(OFS_W), .EXT_W(EXT_W), .SECT_LOG(SECT_LOG)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .op_write(op_write), .op_half(op_half), .op_ext(op_ext),
        .op_cyl_hi(op_cyl_hi), .op_daddr(op_daddr), .op_maddr(op_maddr),
        .drv_present(drv_present), .drv_protect(drv_protect), .stall(stall),
        .busy(busy), .done(done), .faults(faults), .ma_q(ma_out),
        .ext_q(ext_q), .snum_q(snum_q), .dir_q(dir_q), .half_q(half_q),
        .issue(issue), .iss_idx(iss_idx), .s2_v(s2_v), .s2_idx(s2_idx)
    );

    assign idx_slot[0] = iss_idx;
    assign idx_slot[1] = s2_idx;

    // Slot 0 addresses the fetch side, slot 1 the landing side.
    for (genvar g = 0; g < 2; g++) begin : g_addr
        sdma_addr #(.OFS_W(OFS_W), .EXT_W(EXT_W), .SECT_LOG(SECT_LOG)) u_addr (
            .ext(ext_q), .ma(ma_out), .snum(snum_q), .idx(idx_slot[g]),
            .pa(pa_slot[g]), .da(da_slot[g])
        );
    end

    sdma_port #(.WORD_W(WORD_W), .PA_W(PA_W), .DA_W(DA_W)) u_port (
        .dir(dir_q), .half(half_q),
        .issue(issue), .iss_upper(iss_idx[SECT_LOG-1]),
        .s2_v(s2_v), .s2_upper(s2_idx[SECT_LOG-1]),
        .src_pa(pa_slot[0]), .src_da(da_slot[0]),
        .dst_pa(pa_slot[1]), .dst_da(da_slot[1]),
        .mem_rdata(mem_rdata), .dsk_rdata(dsk_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .dsk_en(dsk_en), .dsk_we(dsk_we), .dsk_addr(dsk_addr), .dsk_wdata(dsk_wdata)
    );

    assign err_not_ready = faults.not_ready;
    assign err_drive     = faults.drive_err;
    assign err_wlock     = faults.wlock;

endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
    parameter int OFS_W = 12,
    parameter int EXT_W = 3,
    parameter int PA_W  = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             stall,
    input logic             busy,
    input logic             done,
    input logic             err_not_ready,
    input logic             err_wlock,
    input logic [OFS_W-1:0] ma_out,
    input logic             mem_en,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic             dsk_en,
    input logic             dsk_we
);
    p_busy_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_field_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $past(mem_en) && busy && $past(busy))
        |-> mem_addr[PA_W-1 -: EXT_W] == $past(mem_addr[PA_W-1 -: EXT_W]));

    p_stall_no_fetch_r7: assert property (@(posedge clk) disable iff (rst)
        stall |-> !(dsk_en && !dsk_we) && !(mem_en && !mem_we));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_ma_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !done) |-> $stable(ma_out));

    p_absent_abort_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_not_ready) |-> done && !busy);

    p_wlock_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        err_wlock |-> !dsk_we && !busy);

endmodule

bind sdma_engine sdma_engine_chk #(.OFS_W(OFS_W), .EXT_W(EXT_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .stall(stall), .busy(busy), .done(done),
    .err_not_ready(err_not_ready), .err_wlock(err_wlock), .ma_out(ma_out),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .dsk_en(dsk_en), .dsk_we(dsk_we)
);

// File: tb/sdma_engine_bench.sv
module sdma_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, op_write = 1'b0, op_half = 1'b0, op_cyl_hi = 1'b0;
    logic [2:0]  op_ext = '0;
    logic [11:0] op_daddr = '0, op_maddr = '0;
    logic        drv_present = 1'b1, drv_protect = 1'b0, stall = 1'b0;
    logic        busy, done, err_not_ready, err_drive, err_wlock;
    logic [11:0] ma_out;
    logic        mem_en, mem_we, dsk_en, dsk_we;
    logic [14:0] mem_addr;
    logic [20:0] dsk_addr;
    logic [11:0] mem_wdata, dsk_wdata;
    logic [11:0] mem_rdata = '0, dsk_rdata = '0;

    sdma_engine u_sdma_engine (.*);

    always #10 clk = ~clk;

    int n_vec = 0, n_bad = 0, cyc = 0;
    int mem_m [int];
    int dsk_m [int];
    int q_addr [$];
    int q_data [$];

    // Reference model state
    int m_busy = 0, m_done = 0, m_iss = 0, m_wr = 0, m_pend = 0;
    int m_tot = 0, m_cnt = 0, m_dir = 0, m_ma = 0;
    bit [2:0] m_fault = '0;

    function automatic int rd_mem(int a);
        return mem_m.exists(a) ? mem_m[a] : 0;
    endfunction
    function automatic int rd_dsk(int a);
        return dsk_m.exists(a) ? dsk_m[a] : 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // RAM models: one-cycle read latency, unwritten words read as zero.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_m[int'(mem_addr)] = int'(mem_wdata);
            else mem_rdata <= 12'(rd_mem(int'(mem_addr)));
        end
        if (dsk_en) begin
            if (dsk_we) dsk_m[int'(dsk_addr)] = int'(dsk_wdata);
            else dsk_rdata <= 12'(rd_dsk(int'(dsk_addr)));
        end
    end

    // Cycle model built from the requirements.
    always @(posedge clk) begin
        bit last;
        if (rst) begin
            m_busy = 0; m_done = 0; m_pend = 0; m_ma = 0; m_fault = '0;
        end else if (m_busy == 0) begin
            m_done = 0;
            if (start) begin
                if (!drv_present) begin m_fault = 3'b110; m_done = 1; end
                else if (op_write && drv_protect) begin m_fault = 3'b001; m_done = 1; end
                else begin
                    m_fault = '0; m_busy = 1; m_iss = 0; m_wr = 0; m_pend = 0;
                    m_dir = op_write; m_cnt = op_half ? 128 : 256;
                    m_tot = op_write ? 256 : m_cnt; m_ma = op_maddr;
                end
            end
        end else begin
            m_done = 0;
            last = (m_pend != 0) && (m_wr == m_tot - 1);
            if (m_pend != 0) m_wr++;
            m_pend = (!stall && m_iss < m_tot) ? 1 : 0;
            if (m_pend != 0) m_iss++;
            if (last) begin
                m_busy = 0; m_done = 1; m_pend = 0;
                m_ma = (m_ma + m_cnt) % 4096;
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == m_busy[0], "R2 busy", busy, m_busy);
            chk(done == m_done[0], "R8 done", done, m_done);
            chk(ma_out == 12'(m_ma), "R8 ma_out", ma_out, m_ma);
            chk({err_not_ready, err_drive} == m_fault[2:1], "R9 faults",
                {err_not_ready, err_drive}, m_fault[2:1]);
            chk(err_wlock == m_fault[0], "R10 wlock", err_wlock, m_fault[0]);
            if (m_pend != 0 && q_addr.size() > 0) begin
                if (m_dir == 0) begin
                    chk(mem_we && mem_en && !dsk_we, "R7 landing strobe", mem_we, 1);
                    chk(int'(mem_addr) == q_addr[0], "R3 mem addr", mem_addr, q_addr[0]);
                    chk(int'(mem_wdata) == q_data[0], "R5 mem data", mem_wdata, q_data[0]);
                end else begin
                    chk(dsk_we && dsk_en && !mem_we, "R7 landing strobe", dsk_we, 1);
                    chk(int'(dsk_addr) == q_addr[0], "R4 disk addr", dsk_addr, q_addr[0]);
                    chk(int'(dsk_wdata) == q_data[0], "R6 disk data", dsk_wdata, q_data[0]);
                end
                void'(q_addr.pop_front());
                void'(q_data.pop_front());
            end else begin
                chk(m_pend == 0, "R7 queue underrun", q_addr.size(), 1);
                chk(!mem_we && !dsk_we, "R7 idle strobe", {mem_we, dsk_we}, 0);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R7 watchdog: actual %0d expected 0", cyc);
            summary();
        end
    end

    task automatic xfer(input bit wr, input bit half, input bit [2:0] ext, input bit cyh,
                        input bit [11:0] da, input bit [11:0] ma, input bit pres,
                        input bit prot, input int stall_pct, input bit poke);
        int sn, cnt;
        bit ok;
        @(negedge clk);
        op_write = wr; op_half = half; op_ext = ext; op_cyl_hi = cyh;
        op_daddr = da; op_maddr = ma; drv_present = pres; drv_protect = prot;
        start = 1'b1;
        if (m_busy == 0 && pres && !(wr && prot)) begin
            sn = {cyh, da};                          // R4 linear sector number
            cnt = half ? 128 : 256;
            for (int i = 0; i < 256; i++) begin
                int pa;
                pa = (int'(ext) << 12) | ((int'(ma) + i) % 4096);   // R3 field wrap
                if (!wr && i < cnt) begin
                    q_addr.push_back(pa); q_data.push_back(rd_dsk(sn * 256 + i));
                end else if (wr) begin
                    q_addr.push_back(sn * 256 + i);
                    q_data.push_back(i < cnt ? rd_mem(pa) : 0);     // R6 zero fill
                end
            end
        end
        ok = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin ok = 1'b1; break; end
            stall = (($urandom % 100) < stall_pct);
            if (poke && n == 5) begin       // R2: start while busy is ignored
                start = 1'b1; op_maddr = 12'h777; op_write = ~wr;
            end
        end
        stall = 1'b0;
        chk(ok, "R8 completion seen", ok, 1);
        chk(q_addr.size() == 0, "R5 words landed", q_addr.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            dsk_m[5 * 256 + i]      = (i * 7 + 3) & 12'hFFF;
            dsk_m[4263 * 256 + i]   = (i * 11 + 5) & 12'hFFF;
            dsk_m[8191 * 256 + i]   = 12'hABC;
            mem_m[(1 << 12) | ((12'hFF0 + i) % 4096)] = (i * 13 + 1) & 12'hFFF;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && ma_out == 0 && !err_not_ready && !err_drive && !err_wlock
            && !mem_we && !dsk_we, "R1 reset state", {busy, done, ma_out}, 0);
        rst = 1'b0;
        xfer(0, 0, 3'd2, 0, 12'h005, 12'h100, 1, 0, 0, 0);   // R5 full read
        xfer(0, 1, 3'd5, 1, 12'h0A7, 12'hFC0, 1, 0, 30, 0);  // R5 half read, R3 wrap
        xfer(1, 0, 3'd1, 0, 12'h040, 12'hFF0, 1, 0, 25, 0);  // R6 full write, wrap
        xfer(1, 1, 3'd1, 1, 12'hFFF, 12'h010, 1, 0, 0, 0);   // R6 half write, R4 top sector
        xfer(0, 0, 3'd3, 1, 12'hFFF, 12'h000, 1, 0, 40, 0);  // R6 padded zeros read back
        xfer(0, 0, 3'd4, 0, 12'h001, 12'h200, 0, 0, 0, 0);   // R9 absent drive
        xfer(1, 0, 3'd4, 0, 12'h001, 12'h200, 1, 1, 0, 0);   // R10 protected write
        xfer(0, 1, 3'd6, 0, 12'h005, 12'hF90, 1, 1, 10, 0);  // R10 protected read proceeds
        // R11: faults cleared by the accepted start above
        chk(!err_wlock && !err_not_ready && !err_drive, "R11 faults cleared",
            {err_not_ready, err_drive, err_wlock}, 0);
        xfer(1, 0, 3'd7, 0, 12'h123, 12'h300, 1, 0, 20, 1);  // R2 start while busy
        xfer(0, 0, 3'd7, 1, 12'h000, 12'h400, 1, 0, 0, 0);   // R7 back to back
        repeat (4) @(negedge clk);
        summary();
    end

endmodule